// File: doc/BRIEF.md
# Periodic Driver Impedance Calibrator

This block holds the strength code of an output driver built from binary-weighted legs and keeps that code tracking a target while supply voltage and temperature drift. A free-running cycle counter marks an evaluation slot once every `PERIOD` clock cycles. In that slot the block reads a comparator flag, which says whether the driver is currently weaker or stronger than the target. It then moves the code by a single LSB in the direction that brings the driver closer to the target. A larger code switches on more legs, which gives a lower output impedance.

A strap input requests the minimum-impedance setting. When the strap is high at an evaluation slot, the code goes straight to all ones, whatever the comparator reports. The code never changes outside an evaluation slot. When a slot changes the code, a one-cycle strobe goes out with the new value, so that the driver legs can latch it. The analog comparator, the reference resistor and the driver transistors are outside this block.

Top module: `drive_cal_ctrl`

## Requirements
- R1: While reset is asserted (`rst_n` low) and on the first cycle after release, `drv_code_o` equals mid-scale (2^(CODE_W-1), 32 for the default width) and `code_upd_o` is 0. The interval counter restarts from zero.
- R2: Evaluations fall on the PERIOD-th rising clock edge after reset release and then on every PERIOD-th edge after that (1024 by default). No evaluation happens on any other edge.
- R3: At an evaluation with `force_min_i`=0 and `cmp_weak_i`=1 (driver too weak), the code increases by exactly 1 unless it is already all ones.
- R4: At an evaluation with `force_min_i`=0 and `cmp_weak_i`=0 (driver too strong), the code decreases by exactly 1 unless it is already zero.
- R5: The code saturates and never wraps. A step up at all ones leaves it at all ones, and a step down at zero leaves it at zero. In both cases `code_upd_o` stays 0.
- R6: At an evaluation with `force_min_i`=1, the code becomes all ones (minimum impedance), whatever `cmp_weak_i` is.
- R7: `code_upd_o` is 1 for exactly the one cycle after an evaluation edge that changed the code, and 0 at all other times.
- R8: Values on `cmp_weak_i` and `force_min_i` between evaluation edges have no effect on `drv_code_o` or `code_upd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_weak_i | input | 1 | Comparator flag: 1 = driver impedance above target, 0 = below |
| force_min_i | input | 1 | Strap requesting the minimum-impedance (all-ones) code |
| drv_code_o | output | CODE_W | Binary-weighted driver strength code |
| code_upd_o | output | 1 | One-cycle strobe marking a new code value |

## Verification
The code and the strobe are registered. Both change on the evaluation edge itself and can be observed in the low phase that follows it. The strobe drops again one edge later. The bench counts rising edges from reset release and samples at falling edges. It checks that the code is unchanged and the strobe is low one cycle before each expected evaluation edge, that the new code and the strobe appear just after that edge, and that the strobe has cleared one cycle later. Between slots the bench toggles both inputs, so any evaluation that fires early, or any input that leaks through outside a slot, shows up in the check made just before the slot.

// File: rtl/drive_cal_pkg.sv
package drive_cal_pkg;

    // Action chosen for one evaluation slot
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_FULL = 2'd3
    } step_dir_e;

endpackage

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_o
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);
    localparam bit IS_POW2 = ((PERIOD & (PERIOD - 1)) == 0);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       at_last;

    generate
        if (IS_POW2) begin : g_pow2
            assign at_last = &st_q.cnt;
        end else begin : g_cmp
            assign at_last = (st_q.cnt == LAST_CNT);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (at_last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eval_o = at_last;

    // R2: counter stays inside its interval
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);

    // R2: the slot is followed by a restart from zero
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> (st_q.cnt == '0));

    // R2: two slots never fall on consecutive edges
    p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> !eval_o);

endmodule

// File: rtl/cal_step_decider.sv
module cal_step_decider
    import drive_cal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              cmp_weak_i,
    input  logic              force_min_i,
    input  logic [CODE_W-1:0] code_i,
    output step_dir_e         dir_o
);
    logic at_top;
    logic at_bottom;

    assign at_top    = &code_i;
    assign at_bottom = ~|code_i;

    always_comb begin
        dir_o = STEP_HOLD;
        if (force_min_i) begin
            dir_o = at_top ? STEP_HOLD : STEP_FULL;
        end else if (cmp_weak_i) begin
            dir_o = at_top ? STEP_HOLD : STEP_UP;
        end else begin
            dir_o = at_bottom ? STEP_HOLD : STEP_DOWN;
        end
    end

endmodule

// File: rtl/cal_code_reg.sv
module cal_code_reg
    import drive_cal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  step_dir_e         dir_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } code_state_t;

    code_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (eval_i) begin
            unique case (dir_i)
                STEP_UP:   st_d.code = st_q.code + CODE_ONE;
                STEP_DOWN: st_d.code = st_q.code - CODE_ONE;
                STEP_FULL: st_d.code = '1;
                default:   st_d.code = st_q.code;
            endcase
            st_d.upd = (dir_i != STEP_HOLD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_MID;
            st_q.upd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;

    // R8: no slot, no change
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(code_o));

    // R7: strobe only right after a slot
    p_strobe_after_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(eval_i));

    // R7: every change of the code carries the strobe
    p_change_strobed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> upd_o);

    // R7: the strobe lasts one cycle
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

endmodule

// File: rtl/drive_cal_ctrl.sv
module drive_cal_ctrl
    import drive_cal_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_weak_i,
    input  logic              force_min_i,
    output logic [CODE_W-1:0] drv_code_o,
    output logic              code_upd_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    logic      eval_slot;
    step_dir_e step_dir;

    cal_interval_timer #(
        .PERIOD (PERIOD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval_o (eval_slot)
    );

    cal_step_decider #(
        .CODE_W (CODE_W)
    ) u_decider (
        .cmp_weak_i  (cmp_weak_i),
        .force_min_i (force_min_i),
        .code_i      (drv_code_o),
        .dir_o       (step_dir)
    );

    cal_code_reg #(
        .CODE_W (CODE_W)
    ) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval_i (eval_slot),
        .dir_i  (step_dir),
        .code_o (drv_code_o),
        .upd_o  (code_upd_o)
    );

    // R1: first cycle out of reset shows mid-scale and no strobe
    p_reset_mid_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (drv_code_o == CODE_MID && !code_upd_o));

    // R3: a weak driver gains one leg
    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_slot && !force_min_i && cmp_weak_i && drv_code_o != CODE_MAX)
        |=> (drv_code_o == $past(drv_code_o) + CODE_ONE));

    // R4: a strong driver loses one leg
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_slot && !force_min_i && !cmp_weak_i && drv_code_o != '0)
        |=> (drv_code_o == $past(drv_code_o) - CODE_ONE));

    // R5: no wrap at the top
    p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_slot && !force_min_i && cmp_weak_i && drv_code_o == CODE_MAX)
        |=> (drv_code_o == CODE_MAX && !code_upd_o));

    // R5: no wrap at the bottom
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_slot && !force_min_i && !cmp_weak_i && drv_code_o == '0)
        |=> (drv_code_o == '0 && !code_upd_o));

    // R6: strap forces minimum impedance
    p_force_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_slot && force_min_i) |=> (drv_code_o == CODE_MAX));

endmodule

// File: tb/drive_cal_ctrl_test.sv
module drive_cal_ctrl_test;
    localparam int CODE_W = 6;
    localparam int PERIOD = 1024;

    typedef struct packed {
        logic       cmp;
        logic       frc;
        logic [5:0] code;
        logic       strb;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 6'd33, 1'b1},
        '{1'b1, 1'b0, 6'd34, 1'b1},
        '{1'b0, 1'b0, 6'd33, 1'b1},
        '{1'b0, 1'b0, 6'd32, 1'b1},
        '{1'b0, 1'b1, 6'd63, 1'b1},
        '{1'b1, 1'b0, 6'd63, 1'b0},
        '{1'b0, 1'b0, 6'd62, 1'b1},
        '{1'b1, 1'b1, 6'd63, 1'b1},
        '{1'b0, 1'b1, 6'd63, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_weak_i = 1'b0;
    logic              force_min_i = 1'b0;
    logic [CODE_W-1:0] drv_code_o;
    logic              code_upd_o;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    int target = PERIOD;
    int exp_prev = 32;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    drive_cal_ctrl #(.CODE_W(CODE_W), .PERIOD(PERIOD)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_weak_i  (cmp_weak_i),
        .force_min_i (force_min_i),
        .drv_code_o  (drv_code_o),
        .code_upd_o  (code_upd_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edges);
        end
    endtask

    // Runs up to the next slot with inputs toggling, then applies the
    // real inputs just before the slot edge and checks both sides of it.
    task automatic do_eval(input logic cmp, input logic frc, input int exp_code,
                           input int exp_strb, input string req);
        while (edges != target - 1) begin
            cmp_weak_i  = edges[0];
            force_min_i = edges[1];
            @(negedge clk);
        end
        chk("R8 code before slot", int'(drv_code_o), exp_prev);
        chk("R2 no early strobe", int'(code_upd_o), 0);
        cmp_weak_i  = cmp;
        force_min_i = frc;
        @(negedge clk);
        chk({req, " code after slot"}, int'(drv_code_o), exp_code);
        chk("R7 strobe at slot", int'(code_upd_o), exp_strb);
        @(negedge clk);
        chk("R7 strobe cleared", int'(code_upd_o), 0);
        exp_prev = exp_code;
        target   = target + PERIOD;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(drv_code_o), 32);
        chk("R1 reset strobe", int'(code_upd_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after release", int'(drv_code_o), 32);

        // table-driven sequence
        for (int i = 0; i < NVEC; i++) begin
            string req;
            if (VECS[i].frc)                    req = "R6";
            else if (int'(VECS[i].code) == exp_prev) req = "R5";
            else if (VECS[i].cmp)               req = "R3";
            else                                req = "R4";
            do_eval(VECS[i].cmp, VECS[i].frc, int'(VECS[i].code), int'(VECS[i].strb), req);
        end

        // walk down from all ones to zero
        for (int c = 62; c >= 0; c--) begin
            do_eval(1'b0, 1'b0, c, 1, "R4");
        end
        // floor holds, no strobe
        do_eval(1'b0, 1'b0, 0, 0, "R5");
        do_eval(1'b1, 1'b0, 1, 1, "R3");

        // reset in mid-interval: counter must restart from zero
        repeat (500) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mid-run reset code", int'(drv_code_o), 32);
        chk("R1 mid-run reset strobe", int'(code_upd_o), 0);
        rst_n    = 1'b1;
        target   = PERIOD;
        exp_prev = 32;
        do_eval(1'b1, 1'b0, 33, 1, "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule